// File: doc/BRIEF.md
# Flash Status Register with Sticky Faults

This block sits between the host bus of a flash memory and its internal write state machine. It builds a status byte from the machine's ready/busy state, an erase-suspended indication, two fault flags (erase failure and program failure) and the sector-protect state. It hands that byte to the host as a snapshot taken at the start of each host read cycle. It also tracks which source host reads should come from (memory array, status or identifier), and it decides whether a decoded program or erase command may be passed on to the write state machine.

The two fault flags are sticky. The write state machine can only set them, and only the host's clear-status command resets them. Flags from a run of program or erase operations therefore add up, and one status read at the end of the run shows whether any of them failed. While either flag is set, new page program, sector erase and chip erase commands are refused. Command decoding is done outside this block: it receives a valid strobe and a 3-bit command code. The synchronous reset is applied at power-up and again on wake from deep power-down.

Top module: `flash_status_reg`

## Requirements
- R1: The status word `stat_q` has this layout. Bits 15:8 and 2:0 always read 0. Bit 7 is ready (the inverse of `wsm_busy`). Bit 6 is erase-suspended. Bit 5 is the erase-fail flag. Bit 4 is the program-fail flag. Bit 3 is sector-protect.
- R2: `stat_q` loads the live status one cycle after the first cycle in which `host_ce_n` and `host_oe_n` are both low, following a cycle in which they were not both low. Whichever of the two falls last starts the read. At all other times `stat_q` holds its value, even if the live status changes.
- R3: After reset, `stat_q` is 16'h0080, both fault flags are clear, `rd_src` is 0 (array), `op_start` is 0 and `prog_erase_blocked` is 0.
- R4: A high `wsm_erase_fail` or `wsm_prog_fail` sets the matching flag on the next clock edge. The flag then stays set whatever the write state machine does.
- R5: Clear-status (code 2) with `cmd_valid` clears both flags on the next edge. If a fail input is high in the same cycle, that flag is set instead.
- R6: Bit 3 shows `sect_prot` as sampled at the read start. The clear-status command does not change it.
- R7: `prog_erase_blocked` is high exactly while either flag is set. While it is high, page program (3), sector erase (4) and chip erase (5) give no `op_start` pulse.
- R8: When not blocked, page program, sector erase and chip erase give a one-cycle `op_start` pulse in the next cycle. The pulse is on bit 0, 1 or 2 respectively. Otherwise `op_start` is 0.
- R9: `rd_src` encodes array as 0, status as 1 and identifier as 2. It becomes 1 after read-status (1) or after codes 3, 4 or 5, including refused ones. It becomes 0 after read-array (0) and 2 after read-id (6). Clear-status (2) and code 7 leave it unchanged.
- R10: Fault flags accumulate. A program failure followed by an erase failure shows both bits 5 and 4 set in the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up, deep power-down wake) |
| cmd_valid | input | 1 | Decoded command strobe, one cycle |
| cmd_code | input | 3 | Decoded command code |
| wsm_busy | input | 1 | Write state machine busy |
| wsm_erase_suspended | input | 1 | Erase-suspended indication |
| wsm_erase_fail | input | 1 | Erase failure report from write state machine |
| wsm_prog_fail | input | 1 | Program failure report from write state machine |
| sect_prot | input | 1 | Sector-protect state |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| stat_q | output | 16 | Latched status word for the host data bus |
| rd_src | output | 2 | Read source select: 0 array, 1 status, 2 identifier |
| op_start | output | 3 | One-hot start: program, sector erase, chip erase |
| prog_erase_blocked | output | 1 | A fault is pending and program/erase is refused |

## Verification
The assertions check the following on every cycle: the fixed-zero bits of the status word, that the word stays stable outside a read start, that a fail input sets its flag and the flag survives, that clear-status works, and that no start pulse leaves while blocked. Other behaviour only the bench scenarios can show. This covers whether the snapshot holds the values present at the later-falling strobe, and whether faults from successive operations add up. It also covers the decision that a same-cycle failure beats a clear, and the read-source transitions after refused commands. A behavioural model predicts every output each cycle, and it is compared against the design through these sequences.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int CMD_W  = 3;
  localparam int SRC_W  = 2;
  localparam int N_FLT  = 2;
  localparam int N_OP   = 3;
  localparam int FLT_PROG  = 0;
  localparam int FLT_ERASE = 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_RD_ARRAY   = 3'd0,
    CMD_RD_STATUS  = 3'd1,
    CMD_CLR_STATUS = 3'd2,
    CMD_PAGE_PROG  = 3'd3,
    CMD_SECT_ERASE = 3'd4,
    CMD_CHIP_ERASE = 3'd5,
    CMD_RD_ID      = 3'd6,
    CMD_NONE       = 3'd7
  } cmd_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2
  } src_e;
endpackage

// File: rtl/fsr_fault_flags.sv
module fsr_fault_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fail_set,
  input  logic         clr,
  output logic [N-1:0] flags_q,
  output logic         blocked
);
  // each flag: set has priority over clear so a fault is never lost
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flags_q[i] <= 1'b0;
      else if (fail_set[i]) flags_q[i] <= 1'b1;
      else if (clr)         flags_q[i] <= 1'b0;
    end
  end

  assign blocked = |flags_q;
endmodule

// File: rtl/fsr_cmd_ctrl.sv
module fsr_cmd_ctrl
  import fsr_pkg::*;
#(
  parameter int NOP = N_OP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             blocked,
  output logic             clr_stb,
  output logic [SRC_W-1:0] src_q,
  output logic [NOP-1:0]   op_start_q
);
  logic [NOP-1:0] op_req;
  logic           is_op;

  always_comb begin
    op_req = '0;
    is_op  = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_e'(cmd_code))
        CMD_PAGE_PROG:  begin op_req[0] = 1'b1; is_op = 1'b1; end
        CMD_SECT_ERASE: begin op_req[1] = 1'b1; is_op = 1'b1; end
        CMD_CHIP_ERASE: begin op_req[2] = 1'b1; is_op = 1'b1; end
        default: ;
      endcase
    end
  end

  assign clr_stb = cmd_valid && (cmd_e'(cmd_code) == CMD_CLR_STATUS);

  always_ff @(posedge clk) begin
    if (rst) op_start_q <= '0;
    else     op_start_q <= blocked ? '0 : op_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_ARRAY;
    end else if (is_op) begin
      src_q <= SRC_STATUS;
    end else if (cmd_valid) begin
      case (cmd_e'(cmd_code))
        CMD_RD_ARRAY:  src_q <= SRC_ARRAY;
        CMD_RD_STATUS: src_q <= SRC_STATUS;
        CMD_RD_ID:     src_q <= SRC_ID;
        default:       src_q <= src_q;
      endcase
    end
  end
endmodule

// File: rtl/fsr_snapshot.sv
module fsr_snapshot #(
  parameter int          STAT_W  = 8,
  parameter int          DATA_W  = 16,
  parameter logic [7:0]  RST_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [STAT_W-1:0] live,
  output logic [DATA_W-1:0] stat_q
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic rd_act, rd_prev, rd_start;

  assign rd_act   = !ce_n && !oe_n;
  assign rd_start = rd_act && !rd_prev;

  always_ff @(posedge clk) begin
    if (rst) rd_prev <= 1'b0;
    else     rd_prev <= rd_act;
  end

  always_ff @(posedge clk) begin
    if (rst)           stat_q <= {{PAD_W{1'b0}}, RST_VAL};
    else if (rd_start) stat_q <= {{PAD_W{1'b0}}, live};
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic             wsm_busy,
  input  logic             wsm_erase_suspended,
  input  logic             wsm_erase_fail,
  input  logic             wsm_prog_fail,
  input  logic             sect_prot,
  input  logic             host_ce_n,
  input  logic             host_oe_n,
  output logic [15:0]      stat_q,
  output logic [1:0]       rd_src,
  output logic [2:0]       op_start,
  output logic             prog_erase_blocked
);
  logic [N_FLT-1:0]  flt_q;
  logic [N_FLT-1:0]  flt_set;
  logic              clr_stb;
  logic [STAT_W-1:0] live;

  assign flt_set[FLT_PROG]  = wsm_prog_fail;
  assign flt_set[FLT_ERASE] = wsm_erase_fail;

  // status byte: ready, suspended, erase fail, program fail, protect, 3 zeros
  assign live = {!wsm_busy, wsm_erase_suspended, flt_q[FLT_ERASE],
                 flt_q[FLT_PROG], sect_prot, 3'b000};

  fsr_fault_flags #(.N(N_FLT)) u_flags (
    .clk(clk), .rst(rst), .fail_set(flt_set), .clr(clr_stb),
    .flags_q(flt_q), .blocked(prog_erase_blocked)
  );

  fsr_cmd_ctrl #(.NOP(N_OP)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .blocked(prog_erase_blocked), .clr_stb(clr_stb),
    .src_q(rd_src), .op_start_q(op_start)
  );

  fsr_snapshot #(.STAT_W(STAT_W), .DATA_W(DATA_W), .RST_VAL(8'h80)) u_snap (
    .clk(clk), .rst(rst), .ce_n(host_ce_n), .oe_n(host_oe_n),
    .live(live), .stat_q(stat_q)
  );
endmodule

// File: rtl/flash_status_reg_chk.sv
module flash_status_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [2:0]  cmd_code,
  input logic        wsm_erase_fail,
  input logic        wsm_prog_fail,
  input logic        host_ce_n,
  input logic        host_oe_n,
  input logic [15:0] stat_q,
  input logic [1:0]  rd_src,
  input logic [2:0]  op_start,
  input logic        prog_erase_blocked,
  input logic [1:0]  flt_q
);
  logic rd_prev_c;
  logic rd_now;
  logic clr_cmd;
  logic stat_cmd;

  assign rd_now   = !host_ce_n && !host_oe_n;
  assign clr_cmd  = cmd_valid && cmd_code == 3'd2;
  assign stat_cmd = cmd_valid && (cmd_code == 3'd1 || cmd_code == 3'd3 ||
                                  cmd_code == 3'd4 || cmd_code == 3'd5);

  always_ff @(posedge clk) begin
    if (rst) rd_prev_c <= 1'b0;
    else     rd_prev_c <= rd_now;
  end

  p_fixed_zero_r1: assert property (@(posedge clk) disable iff (rst)
    stat_q[15:8] == 8'h00 && stat_q[2:0] == 3'b000);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(rd_now && !rd_prev_c) |=> $stable(stat_q));

  p_erase_set_r4: assert property (@(posedge clk) disable iff (rst)
    wsm_erase_fail |=> flt_q[1]);

  p_prog_set_r4: assert property (@(posedge clk) disable iff (rst)
    wsm_prog_fail |=> flt_q[0]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (flt_q[1] && !clr_cmd) |=> flt_q[1]);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_cmd && !wsm_erase_fail && !wsm_prog_fail) |=> flt_q == 2'b00);

  p_no_start_r7: assert property (@(posedge clk) disable iff (rst)
    prog_erase_blocked |=> op_start == 3'b000);

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(op_start));

  p_src_status_r9: assert property (@(posedge clk) disable iff (rst)
    stat_cmd |=> rd_src == 2'd1);
endmodule

bind flash_status_reg flash_status_reg_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .wsm_erase_fail(wsm_erase_fail), .wsm_prog_fail(wsm_prog_fail),
  .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .stat_q(stat_q),
  .rd_src(rd_src), .op_start(op_start),
  .prog_erase_blocked(prog_erase_blocked), .flt_q(flt_q)
);

// File: tb/tb_flash_status_reg.sv
module tb_flash_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd7;
  logic busy = 1'b0, susp = 1'b0, efail = 1'b0, pfail = 1'b0, prot = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [15:0] stat_q;
  logic [1:0]  rd_src;
  logic [2:0]  op_start;
  logic        blocked;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R3";

  // reference model state
  logic [15:0] m_stat;
  logic [1:0]  m_src;
  logic [2:0]  m_start;
  bit m_ef, m_pf, m_prev;

  always #4 clk = ~clk;

  flash_status_reg dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wsm_busy(busy), .wsm_erase_suspended(susp), .wsm_erase_fail(efail),
    .wsm_prog_fail(pfail), .sect_prot(prot), .host_ce_n(ce_n),
    .host_oe_n(oe_n), .stat_q(stat_q), .rd_src(rd_src),
    .op_start(op_start), .prog_erase_blocked(blocked)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_tick();
    bit act;
    act = !ce_n && !oe_n;
    if (rst) begin
      m_stat = 16'h0080; m_src = 2'd0; m_start = 3'b000;
      m_ef = 0; m_pf = 0; m_prev = 0;
      return;
    end
    if (act && !m_prev)
      m_stat = {8'h00, ~busy, susp, m_ef ? 1'b1 : 1'b0, m_pf ? 1'b1 : 1'b0, prot, 3'b000};
    m_prev = act;
    m_start = 3'b000;
    if (cmd_valid) begin
      case (cmd_code)
        3'd3, 3'd4, 3'd5: begin
          if (!(m_ef || m_pf)) m_start = 3'b001 << (cmd_code - 3'd3);
          m_src = 2'd1;
        end
        3'd1: m_src = 2'd1;
        3'd0: m_src = 2'd0;
        3'd6: m_src = 2'd2;
        default: ;
      endcase
    end
    if (efail) m_ef = 1; else if (cmd_valid && cmd_code == 3'd2) m_ef = 0;
    if (pfail) m_pf = 1; else if (cmd_valid && cmd_code == 3'd2) m_pf = 0;
  endtask

  // one clock: inputs already driven, advance, then compare away from the edge
  task automatic step();
    @(posedge clk);
    #1;
    model_tick();
    check(tag, "stat_q", stat_q, m_stat);
    check(tag, "rd_src", {14'd0, rd_src}, {14'd0, m_src});
    check(tag, "op_start", {13'd0, op_start}, {13'd0, m_start});
    check(tag, "blocked", {15'd0, blocked}, {15'd0, (m_ef || m_pf) ? 1'b1 : 1'b0});
  endtask

  task automatic cmd(input logic [2:0] c);
    cmd_valid = 1'b1; cmd_code = c; step();
    cmd_valid = 1'b0; cmd_code = 3'd7;
  endtask

  task automatic read_cycle();
    ce_n = 1'b0; oe_n = 1'b0; step(); step();
    ce_n = 1'b1; oe_n = 1'b1; step();
  endtask

  initial begin
    #1;
    repeat (3) step();
    rst = 1'b0;
    tag = "R3"; step();
    check("R3", "reset stat", stat_q, 16'h0080);
    check("R3", "reset src", {14'd0, rd_src}, 16'd0);

    // R1 layout and R6 protect bit on an idle read
    tag = "R1"; prot = 1'b1; read_cycle();
    check("R1", "idle read", stat_q, 16'h0088);

    // R2: busy read, ce falls first, oe later; busy ends mid-read -> held
    tag = "R2"; busy = 1'b1; ce_n = 1'b0; step(); step();
    oe_n = 1'b0; step();
    busy = 1'b0; step(); step();
    check("R2", "held busy snapshot", stat_q, 16'h0008);
    ce_n = 1'b1; oe_n = 1'b1; step();
    read_cycle();
    check("R2", "new read ready", stat_q, 16'h0088);

    // R4 program fail sets flag; R7 program refused; R9 src status
    tag = "R4"; pfail = 1'b1; step(); pfail = 1'b0; step();
    check("R7", "blocked after fail", {15'd0, blocked}, 16'd1);
    tag = "R7"; cmd(3'd3);
    check("R7", "no start when blocked", {13'd0, op_start}, 16'd0);
    check("R9", "src status after refused prog", {14'd0, rd_src}, 16'd1);
    read_cycle();
    check("R4", "program fail bit", stat_q, 16'h0098);

    // R10 accumulate with erase fail
    tag = "R10"; efail = 1'b1; step(); efail = 1'b0;
    cmd(3'd4); read_cycle();
    check("R10", "both faults", stat_q, 16'h00B8);

    // R5 clear; R6 protect unchanged; src unchanged
    tag = "R5"; cmd(3'd2); step();
    check("R9", "clear keeps src", {14'd0, rd_src}, 16'd1);
    read_cycle();
    check("R5", "cleared", stat_q, 16'h0088);
    check("R6", "protect after clear", stat_q[3:0], 16'h8);

    // R5 set wins over same-cycle clear
    tag = "R5"; efail = 1'b1; cmd_valid = 1'b1; cmd_code = 3'd2; step();
    efail = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd7; step();
    check("R5", "set beats clear", {15'd0, blocked}, 16'd1);
    cmd(3'd2); step();

    // R8 accepted starts
    tag = "R8"; cmd(3'd3);
    check("R8", "prog start", {13'd0, op_start}, 16'd1);
    step();
    check("R8", "pulse one cycle", {13'd0, op_start}, 16'd0);
    cmd(3'd4);
    check("R8", "sector start", {13'd0, op_start}, 16'd2);
    cmd(3'd5);
    check("R8", "chip start", {13'd0, op_start}, 16'd4);

    // R9 source transitions, reserved code
    tag = "R9"; cmd(3'd6);
    check("R9", "read id", {14'd0, rd_src}, 16'd2);
    cmd(3'd7);
    check("R9", "reserved no change", {14'd0, rd_src}, 16'd2);
    cmd(3'd0);
    check("R9", "read array", {14'd0, rd_src}, 16'd0);
    cmd(3'd1);
    check("R9", "read status", {14'd0, rd_src}, 16'd1);

    // R1 suspend bit, protect low
    tag = "R1"; susp = 1'b1; prot = 1'b0; busy = 1'b1; read_cycle();
    check("R1", "suspend bit", stat_q, 16'h0040);
    susp = 1'b0; busy = 1'b0; step();

    // R3 reset clears pending fault
    tag = "R3"; pfail = 1'b1; step(); pfail = 1'b0;
    rst = 1'b1; step(); rst = 1'b0; step();
    check("R3", "reset clears fault", {15'd0, blocked}, 16'd0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule